// File: doc/BRIEF.md
# Ping-Pong Tile Load Sequencer

This block keeps a compute engine busy on a stream of fixed-size tiles that sit in external memory. Two scratchpad banks are used in turn. While the engine works on the tile in one bank, the block has the next tile copied into the other bank. When both jobs have finished, the roles of the two banks swap. The block only issues commands. A DMA command port carries the start pulse, source, destination and byte count, and returns a done pulse. A compute command port carries the start pulse and the bank base, and also returns a done pulse. The block does not move any data itself.

A job begins with a one-cycle `go` pulse, which samples a source base address and a tile count. The first tile is loaded into bank 0 on its own. Each later step then starts compute on the current bank and, in the same cycle, starts a prefetch of the following tile into the other bank. No prefetch is issued after the final tile. The `all_done` flag rises when the last compute pass has finished.

Top module: `tile_pingpong_seq`

## Requirements
- R1: A `go` with `tile_cnt` equal to 0 raises `all_done` one cycle later and issues no DMA or compute start.
- R2: A `go` with a nonzero count pulses `dma_start` one cycle later with `dma_src` = `src_base`, `dma_dst` = bank 0 base (0x5000_0000) and `dma_len` = 16384. No compute start appears until that DMA has reported done.
- R3: One cycle after the initial load's `dma_done`, `cmp_start` pulses with `cmp_base` set to the bank 0 base.
- R4: Every compute start for tile t with t+1 < count is joined, in the same cycle, by a prefetch with `dma_src` = `src_base` + (t+1)·16384 and `dma_dst` = the base of the bank not being computed on.
- R5: The compute start for the last tile comes with no DMA start. A count of 1 therefore produces exactly one load and one compute pass.
- R6: The next compute start, or `all_done`, appears exactly one cycle after the later of the compute done and the outstanding prefetch done. The two done pulses may arrive in either order or in the same cycle.
- R7: Successive compute passes of a job alternate between bank 0 (0x5000_0000) and bank 1 (0x5008_0000), starting with bank 0.
- R8: `dma_start` and `cmp_start` are never high for two cycles in a row.
- R9: A `go` that arrives while a job is in progress has no effect on the addresses, the count or the command sequence.
- R10: `all_done` rises one cycle after the last compute done and stays high until the cycle after the next accepted `go`. While it is high, no start is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Job start pulse |
| src_base | input | 32 | External address of tile 0 |
| tile_cnt | input | 16 | Number of tiles in the job |
| dma_start | output | 1 | DMA command pulse |
| dma_src | output | 32 | DMA source address |
| dma_dst | output | 32 | DMA destination (bank base) |
| dma_len | output | 32 | DMA byte count |
| dma_done | input | 1 | DMA completion pulse |
| cmp_start | output | 1 | Compute command pulse |
| cmp_base | output | 32 | Bank base for the compute pass |
| cmp_done | input | 1 | Compute completion pulse |
| all_done | output | 1 | Job complete, held until next job |

## Verification
Every output is a register, so each result is due exactly one cycle after the input that causes it. That input can be a `go`, the initial `dma_done`, or the later of the two done pulses that close a step. The bench drives inputs on the falling edge. It reads the outputs on the next falling edge, which makes the one-cycle response visible there. While it waits for done pulses, it checks at every intermediate falling edge that no early start or `all_done` has appeared. It applies the two done pulses in both orders and in the same cycle, with different latencies.

// File: rtl/tile_pingpong_seq.sv
module tile_pingpong_seq #(
  parameter int AW = 32,
  parameter int CNT_W = 16,
  parameter int LEN_W = 32,
  parameter int TILE_BYTES = 16384,
  parameter logic [AW-1:0] BANK_BASE = 32'h5000_0000,
  parameter logic [AW-1:0] BANK_STRIDE = 32'h0008_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [AW-1:0]    src_base,
  input  logic [CNT_W-1:0] tile_cnt,
  output logic             dma_start,
  output logic [AW-1:0]    dma_src,
  output logic [AW-1:0]    dma_dst,
  output logic [LEN_W-1:0] dma_len,
  input  logic             dma_done,
  output logic             cmp_start,
  output logic [AW-1:0]    cmp_base,
  input  logic             cmp_done,
  output logic             all_done
);
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN} st_t;

  st_t              st;
  logic [AW-1:0]    src_q;
  logic [CNT_W-1:0] cnt_q, tile;
  logic             bank, dma_seen, cmp_seen;

  logic [CNT_W-1:0] nt;
  logic             nb, has_pf, last, both, launch;
  logic [AW-1:0]    pf_src;

  function automatic logic [AW-1:0] bank_addr(input logic b);
    return b ? BANK_BASE + BANK_STRIDE : BANK_BASE;
  endfunction

  assign nt     = (st == S_LOAD) ? '0 : tile + 1'b1;
  assign nb     = (st == S_LOAD) ? 1'b0 : ~bank;
  assign has_pf = ({1'b0, nt} + 1'b1) < {1'b0, cnt_q};
  assign last   = ({1'b0, tile} + 1'b1) == {1'b0, cnt_q};
  assign both   = (cmp_seen | cmp_done) & (dma_seen | dma_done);
  assign launch = (st == S_LOAD && dma_done) || (st == S_RUN && both && !last);
  assign pf_src = src_q + (AW'(nt) + AW'(1)) * AW'(TILE_BYTES);
  assign dma_len = LEN_W'(TILE_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      src_q <= '0;
      cnt_q <= '0;
      tile <= '0;
      bank <= 1'b0;
      dma_seen <= 1'b0;
      cmp_seen <= 1'b0;
      dma_start <= 1'b0;
      dma_src <= '0;
      dma_dst <= '0;
      cmp_start <= 1'b0;
      cmp_base <= '0;
      all_done <= 1'b0;
    end else begin
      dma_start <= 1'b0;
      cmp_start <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          src_q <= src_base;
          cnt_q <= tile_cnt;
          if (tile_cnt == '0) all_done <= 1'b1;
          else begin
            all_done <= 1'b0;
            dma_start <= 1'b1;
            dma_src <= src_base;
            dma_dst <= bank_addr(1'b0);
            st <= S_LOAD;
          end
        end
        S_RUN: begin
          cmp_seen <= cmp_seen | cmp_done;
          dma_seen <= dma_seen | dma_done;
          if (both && last) begin
            all_done <= 1'b1;
            st <= S_IDLE;
          end
        end
        default: ;
      endcase
      if (launch) begin
        tile <= nt;
        bank <= nb;
        cmp_start <= 1'b1;
        cmp_base <= bank_addr(nb);
        cmp_seen <= 1'b0;
        dma_seen <= !has_pf;
        if (has_pf) begin
          dma_start <= 1'b1;
          dma_src <= pf_src;
          dma_dst <= bank_addr(~nb);
        end
        st <= S_RUN;
      end
    end
  end
endmodule

// File: rtl/tile_pingpong_seq_chk.sv
module tile_pingpong_seq_chk #(
  parameter int AW = 32,
  parameter logic [AW-1:0] BANK_BASE = 32'h5000_0000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dma_start,
  input logic [AW-1:0] dma_dst,
  input logic          cmp_start,
  input logic [AW-1:0] cmp_base,
  input logic          all_done
);
  logic          have_prev;
  logic [AW-1:0] prev_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_base <= '0;
    end else if (all_done) begin
      have_prev <= 1'b0;
    end else if (cmp_start) begin
      have_prev <= 1'b1;
      prev_base <= cmp_base;
    end
  end

  a_r8_dma_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |=> !dma_start);
  a_r8_cmp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_start |=> !cmp_start);
  a_r4_other_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_start && dma_start) |-> dma_dst != cmp_base);
  a_r7_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_start && have_prev) |-> cmp_base != prev_base);
  a_r7_first_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_start && !have_prev) |-> cmp_base == BANK_BASE);
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |-> (!dma_start && !cmp_start));
endmodule

bind tile_pingpong_seq tile_pingpong_seq_chk #(.AW(AW), .BANK_BASE(BANK_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_start(dma_start), .dma_dst(dma_dst),
  .cmp_start(cmp_start), .cmp_base(cmp_base), .all_done(all_done));

// File: tb/tile_pingpong_seq_test.sv
module tile_pingpong_seq_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, go, dma_done, cmp_done;
  logic [31:0] src_base;
  logic [15:0] tile_cnt;
  logic        dma_start, cmp_start, all_done;
  logic [31:0] dma_src, dma_dst, dma_len, cmp_base;
  int n_chk = 0, n_bad = 0;

  tile_pingpong_seq uut (
    .clk(clk), .rst_n(rst_n), .go(go), .src_base(src_base), .tile_cnt(tile_cnt),
    .dma_start(dma_start), .dma_src(dma_src), .dma_dst(dma_dst), .dma_len(dma_len),
    .dma_done(dma_done), .cmp_start(cmp_start), .cmp_base(cmp_base),
    .cmp_done(cmp_done), .all_done(all_done));

  function automatic logic [31:0] bank_addr(input int b);
    return (b % 2) ? 32'h5008_0000 : 32'h5000_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic do_zero(input logic [31:0] base);
    @(negedge clk); go = 1; src_base = base; tile_cnt = 0;
    @(negedge clk); go = 0;
    chk(all_done == 1, "R1 all_done", all_done, 1);
    for (int k = 0; k < 3; k++) begin
      chk(!dma_start && !cmp_start, "R1 no command", {dma_start, cmp_start}, 0);
      @(negedge clk);
    end
  endtask

  task automatic run(input int n, input logic [31:0] base, input int dlat, input int clat, input bit poke);
    @(negedge clk); go = 1; src_base = base; tile_cnt = 16'(n);
    @(negedge clk); go = 0; src_base = 32'hDEAD_0000; tile_cnt = 16'd9;
    chk(all_done == 0, "R10 cleared by go", all_done, 0);
    chk(dma_start == 1, "R2 load start", dma_start, 1);
    chk(dma_src == base, "R2 load src", dma_src, base);
    chk(dma_dst == bank_addr(0), "R2 load dst", dma_dst, bank_addr(0));
    chk(dma_len == 32'd16384, "R2 len", dma_len, 32'd16384);
    for (int k = 0; k < dlat; k++) begin
      if (poke && k == 0) begin go = 1; src_base = 32'h1234_0000; tile_cnt = 16'd1; end
      @(negedge clk);
      go = 0;
      chk(!cmp_start, "R2 no early compute", cmp_start, 0);
      if (poke && k == 0) chk(!dma_start, "R9 busy go ignored", dma_start, 0);
    end
    dma_done = 1;
    @(negedge clk); dma_done = 0;
    for (int t = 0; t < n; t++) begin
      bit pf = (t + 1 < n);
      int cl = (t % 2) ? dlat : clat;
      int dl = (t % 2) ? clat : dlat;
      int m = (pf && dl > cl) ? dl : cl;
      chk(cmp_start == 1, "R3 compute start", cmp_start, 1);
      chk(cmp_base == bank_addr(t), "R7 bank", cmp_base, bank_addr(t));
      chk(dma_start == pf, "R5 prefetch presence", dma_start, 32'(pf));
      if (pf) begin
        chk(dma_src == base + 32'(t + 1) * 32'd16384, "R4 prefetch src", dma_src, base + 32'(t + 1) * 32'd16384);
        chk(dma_dst == bank_addr(t + 1), "R4 prefetch dst", dma_dst, bank_addr(t + 1));
      end
      for (int k = 1; k <= m; k++) begin
        cmp_done = (k == cl);
        dma_done = pf && (k == dl);
        @(negedge clk);
        cmp_done = 0; dma_done = 0;
        if (k < m) chk(!cmp_start && !all_done, "R6 wait for both", {cmp_start, all_done}, 0);
      end
    end
    chk(all_done == 1, "R10 all_done after last", all_done, 1);
    chk(!cmp_start && !dma_start, "R5 no extra command", {cmp_start, dma_start}, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(all_done == 1, "R10 all_done held", all_done, 1);
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; go = 0; dma_done = 0; cmp_done = 0; src_base = 0; tile_cnt = 0;
    repeat (3) @(negedge clk);
    chk(!dma_start && !cmp_start && !all_done, "R8 reset quiet", {dma_start, cmp_start, all_done}, 0);
    rst_n = 1;
    do_zero(32'h0100_0000);
    run(1, 32'h0200_0000, 2, 3, 0);
    run(4, 32'h0300_0000, 3, 1, 0);
    run(5, 32'h0400_0000, 2, 2, 0);
    run(3, 32'h0500_0000, 1, 4, 1);
    do_zero(32'h0600_0000);
    run(2, 32'h0700_0000, 4, 1, 0);
    summary();
    $finish;
  end
endmodule